// File: doc/BRIEF.md
# Stop-Mode Power and Wake Controller

This controller puts a microcontroller into its deepest low-power state and brings it back out. Software asks for entry by writing a control word with the all-clocks-stop bit set. If the oscillation-stop-detect field in that same write is 00, the controller gates off the oscillator enable, the CPU clock enable and the peripheral clock enable. At that moment it also forces the clock divider to divide-by-8 and the main-oscillator drive strength to high. If the field is not 00, the request is refused and an error flag is raised.

While stopped, the controller watches two things: the asynchronous hardware reset and a vector of peripheral interrupt requests. Each request carries a 3-bit priority level. A request wakes the block only when its level is nonzero and the global interrupt-enable input is 1. After an interrupt wake, the oscillator enable returns at once. The CPU and peripheral clock enables stay low for a fixed settling window. When that window ends, a one-cycle acknowledge tells the CPU to take the interrupt. The CPU then runs at one eighth of the source it used before entry. During stop, the controller also holds the crystal-output pin and the other pins.

Top module: `stop_wake_ctrl`

## Requirements
- R1: One cycle after a write in run with ctl_stop=1 and ctl_osd=00, stop_flag is 1 and osc_en, cpu_clk_en and per_clk_en are all 0, unless R9 applies.
- R2: On the same clock edge that accepts entry, div_sel becomes 2'b11 (the divide-by-8 code) and drive_hi becomes 1. clk_src and the crystal-pin mode take the values in the write.
- R3: While stop_flag is 1, a request irq_req[i]=1 whose level irq_lvl[3i+2:3i] is not 000 wakes the block when gie=1. On the next cycle stop_flag is 0 and osc_en is 1. A request with level 000, or any request while gie=0, leaves the block stopped.
- R4: After a wake, osc_en stays 1 while cpu_clk_en and per_clk_en stay 0 for exactly SETTLE_CYCLES cycles. Both enables then go to 1 together, and wake_ack is 1 for exactly that first run cycle.
- R5: After an interrupt wake, div_sel stays 2'b11 and clk_src keeps the value it had before entry.
- R6: Hardware reset (rst_n=0), whether in run or in stop, at once returns the block to run with div_sel=00, drive_hi=0, clk_src=0, xout_oe=0 and err_refused=0.
- R7: While stop_flag is 1, pin_hold is 1. When the crystal-pin mode bit is 1, xout_oe=1 and xout_hi=1. When the bit is 0, xout_oe=0 and xout_hi=0. Outside stop, xout_hi is 0 and pin_hold is 0.
- R8: A stop write with ctl_osd not 00 leaves the block in run and sets err_refused to 1. The next write that does not refuse clears err_refused.
- R9: If a qualifying wake (as in R3) is present in the same cycle as an accepted entry write, the block goes straight to settling: stop_flag stays 0 and osc_en stays 1, while R2's forced settings still apply.
- R10: Control writes made while cpu_clk_en is 0 change nothing; div_sel, drive_hi and clk_src keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_stop | input | 1 | All-clocks-stop request bit |
| ctl_div | input | 2 | Clock-divide select to write (11 = divide-by-8) |
| ctl_drive | input | 1 | Main-oscillator drive strength to write (1 = high) |
| ctl_xpin | input | 1 | Crystal-pin mode to write (1 = crystal pins) |
| ctl_src | input | 1 | CPU clock source select to write |
| ctl_osd | input | 2 | Oscillation-stop-detect field; must be 00 for entry |
| irq_req | input | N_IRQ | Peripheral interrupt requests |
| irq_lvl | input | 3*N_IRQ | Priority level per request, 3 bits each |
| gie | input | 1 | Global interrupt enable |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| stop_flag | output | 1 | All-clocks-stop bit readback; clears on wake |
| div_sel | output | 2 | Current clock-divide select |
| drive_hi | output | 1 | Current drive-strength setting |
| clk_src | output | 1 | Current CPU clock source select |
| xout_oe | output | 1 | Crystal-output pin output enable |
| xout_hi | output | 1 | Crystal-output pin driven-high level |
| pin_hold | output | 1 | Hold all other pins at their pre-entry state |
| err_refused | output | 1 | Last stop request was refused |
| wake_ack | output | 1 | One-cycle acknowledge of an interrupt wake |

## Verification
A wrong state register shows at the clock enables within one cycle, because osc_en, cpu_clk_en and stop_flag decode the state directly. A wrong settling count shows only at the end of the window, as a cpu_clk_en edge or a wake_ack pulse that comes early or late. A flawed wake qualifier, such as one that ignores a level of 000 or ignores gie, shows one cycle after the request as a stop_flag that clears when it should not, or stays set when it should clear. The reference model is compared with every output on every clock, so each of these errors is seen in the cycle it first appears.

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
  parameter int N_IRQ         = 8,
  parameter int LVL_W         = 3,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_we,
  input  logic                   ctl_stop,
  input  logic [1:0]             ctl_div,
  input  logic                   ctl_drive,
  input  logic                   ctl_xpin,
  input  logic                   ctl_src,
  input  logic [1:0]             ctl_osd,
  input  logic [N_IRQ-1:0]       irq_req,
  input  logic [N_IRQ*LVL_W-1:0] irq_lvl,
  input  logic                   gie,
  output logic                   osc_en,
  output logic                   cpu_clk_en,
  output logic                   per_clk_en,
  output logic                   stop_flag,
  output logic [1:0]             div_sel,
  output logic                   drive_hi,
  output logic                   clk_src,
  output logic                   xout_oe,
  output logic                   xout_hi,
  output logic                   pin_hold,
  output logic                   err_refused,
  output logic                   wake_ack
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_SETTLE} state_t;

  state_t         st;
  logic [CW-1:0]  cnt;
  logic           xpin;
  logic [N_IRQ-1:0] armed;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_arm
    assign armed[i] = irq_req[i] && (irq_lvl[i*LVL_W +: LVL_W] != '0);
  end

  wire wake_irq = gie && (|armed);
  wire in_run   = (st == S_RUN);
  wire stop_req = in_run && ctl_we && ctl_stop;
  wire refuse   = stop_req && (ctl_osd != 2'b00);
  wire enter    = stop_req && !refuse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_RUN;
      cnt         <= '0;
      div_sel     <= 2'b00;
      drive_hi    <= 1'b0;
      clk_src     <= 1'b0;
      xpin        <= 1'b0;
      err_refused <= 1'b0;
      wake_ack    <= 1'b0;
    end else begin
      wake_ack <= 1'b0;
      case (st)
        S_RUN: if (ctl_we) begin
          div_sel     <= ctl_div;
          drive_hi    <= ctl_drive;
          clk_src     <= ctl_src;
          xpin        <= ctl_xpin;
          err_refused <= refuse;
          if (enter) begin
            div_sel  <= 2'b11;
            drive_hi <= 1'b1;
            cnt      <= CNT_LOAD;
            st       <= wake_irq ? S_SETTLE : S_STOP;
          end
        end
        S_STOP: if (wake_irq) begin
          cnt <= CNT_LOAD;
          st  <= S_SETTLE;
        end
        S_SETTLE: if (cnt == '0) begin
          st       <= S_RUN;
          wake_ack <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign stop_flag  = (st == S_STOP);
  assign osc_en     = !stop_flag;
  assign cpu_clk_en = in_run;
  assign per_clk_en = in_run;
  assign pin_hold   = stop_flag;
  assign xout_oe    = xpin;
  assign xout_hi    = stop_flag && xpin;
endmodule

module stop_wake_chk #(
  parameter int N_IRQ = 8,
  parameter int LVL_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ctl_we,
  input logic                   ctl_stop,
  input logic [1:0]             ctl_osd,
  input logic [N_IRQ-1:0]       irq_req,
  input logic [N_IRQ*LVL_W-1:0] irq_lvl,
  input logic                   gie,
  input logic                   osc_en,
  input logic                   cpu_clk_en,
  input logic                   per_clk_en,
  input logic                   stop_flag,
  input logic [1:0]             div_sel,
  input logic                   drive_hi,
  input logic                   clk_src,
  input logic                   xout_oe,
  input logic                   xout_hi,
  input logic                   err_refused,
  input logic                   wake_ack
);
  logic wq;
  always_comb begin
    wq = 1'b0;
    for (int i = 0; i < N_IRQ; i++)
      if (irq_req[i] && irq_lvl[i*LVL_W +: LVL_W] != '0) wq = 1'b1;
    wq = wq && gie;
  end

  AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag |-> (!osc_en && !cpu_clk_en && !per_clk_en)); // R1
  AST_ENTRY_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> (div_sel == 2'b11 && drive_hi)); // R2
  AST_WAKE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_flag && wq) |=> (!stop_flag && osc_en)); // R3
  AST_WAKE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_flag && !wq) |=> stop_flag); // R3
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |=> !wake_ack); // R4
  AST_ACK_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |-> (cpu_clk_en && per_clk_en)); // R4
  AST_OSC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $past(osc_en)); // R4
  AST_XOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag |-> (xout_hi == xout_oe)); // R7
  AST_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && ctl_we && ctl_stop && ctl_osd != 2'b00) |=> (err_refused && cpu_clk_en)); // R8
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |=> ($stable(div_sel) && $stable(clk_src))); // R10
endmodule

bind stop_wake_ctrl stop_wake_chk #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_stop(ctl_stop), .ctl_osd(ctl_osd),
  .irq_req(irq_req), .irq_lvl(irq_lvl), .gie(gie), .osc_en(osc_en),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .stop_flag(stop_flag),
  .div_sel(div_sel), .drive_hi(drive_hi), .clk_src(clk_src), .xout_oe(xout_oe),
  .xout_hi(xout_hi), .err_refused(err_refused), .wake_ack(wake_ack));

// File: tb/stop_wake_ctrl_test.sv
module stop_wake_ctrl_test;
  localparam int N = 8;
  localparam int SETTLE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_stop = 0, ctl_drive = 0, ctl_xpin = 0, ctl_src = 0, gie = 0;
  logic [1:0] ctl_div = 0, ctl_osd = 0;
  logic [N-1:0] irq_req = '0;
  logic [N*3-1:0] irq_lvl = '0;
  logic osc_en, cpu_clk_en, per_clk_en, stop_flag, drive_hi, clk_src;
  logic xout_oe, xout_hi, pin_hold, err_refused, wake_ack;
  logic [1:0] div_sel;

  always #2 clk = ~clk;

  stop_wake_ctrl #(.N_IRQ(N), .LVL_W(3), .SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_stop(ctl_stop), .ctl_div(ctl_div),
    .ctl_drive(ctl_drive), .ctl_xpin(ctl_xpin), .ctl_src(ctl_src), .ctl_osd(ctl_osd),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .gie(gie), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .stop_flag(stop_flag),
    .div_sel(div_sel), .drive_hi(drive_hi), .clk_src(clk_src), .xout_oe(xout_oe),
    .xout_hi(xout_hi), .pin_hold(pin_hold), .err_refused(err_refused), .wake_ack(wake_ack));

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model: mode 0 run, 1 stop, 2 settling
  int m_mode, m_left, m_div, m_drive, m_src, m_xpin, m_err, m_ack;

  function automatic bit wake_now();
    int hit = 0;
    for (int i = 0; i < N; i++)
      if (irq_req[i] == 1'b1 && irq_lvl[i*3 +: 3] != 3'd0) hit = 1;
    return (hit == 1) && (gie == 1'b1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_div = 0; m_drive = 0; m_src = 0;
      m_xpin = 0; m_err = 0; m_ack = 0;
    end else begin
      m_ack = 0;
      if (m_mode == 2) begin
        m_left = m_left - 1;
        if (m_left == 0) begin m_mode = 0; m_ack = 1; end
      end else if (m_mode == 1) begin
        if (wake_now()) begin m_mode = 2; m_left = SETTLE; end
      end else if (ctl_we) begin
        m_div = ctl_div; m_drive = ctl_drive; m_src = ctl_src; m_xpin = ctl_xpin;
        m_err = (ctl_stop && ctl_osd != 0) ? 1 : 0;
        if (ctl_stop && ctl_osd == 0) begin
          m_div = 3; m_drive = 1;
          if (wake_now()) begin m_mode = 2; m_left = SETTLE; end
          else m_mode = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R1 osc_en",     osc_en,     m_mode != 1);
    chk("R4 cpu_clk_en", cpu_clk_en, m_mode == 0);
    chk("R4 per_clk_en", per_clk_en, m_mode == 0);
    chk("R3 stop_flag",  stop_flag,  m_mode == 1);
    chk("R2 div_sel",    div_sel,    m_div);
    chk("R2 drive_hi",   drive_hi,   m_drive);
    chk("R5 clk_src",    clk_src,    m_src);
    chk("R7 xout_oe",    xout_oe,    m_xpin);
    chk("R7 xout_hi",    xout_hi,    (m_mode == 1) && (m_xpin == 1));
    chk("R7 pin_hold",   pin_hold,   m_mode == 1);
    chk("R8 err",        err_refused, m_err);
    chk("R4 wake_ack",   wake_ack,   m_ack);
  end

  task automatic wr(input bit stp, input bit [1:0] dv, input bit drv, input bit xp,
                    input bit sr, input bit [1:0] od);
    @(posedge clk); #1;
    ctl_we = 1; ctl_stop = stp; ctl_div = dv; ctl_drive = drv;
    ctl_xpin = xp; ctl_src = sr; ctl_osd = od;
    @(posedge clk); #1;
    ctl_we = 0; ctl_stop = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk("R6 reset div", div_sel, 0);
    chk("R6 reset run", cpu_clk_en, 1);

    wr(0, 2'b01, 0, 1, 1, 2'b00);
    wr(1, 2'b01, 0, 1, 1, 2'b01);
    chk("R8 refused err", err_refused, 1);
    chk("R8 refused stays run", cpu_clk_en, 1);
    wr(0, 2'b01, 0, 1, 1, 2'b00);
    chk("R8 err cleared", err_refused, 0);

    wr(1, 2'b01, 0, 1, 1, 2'b00);
    chk("R1 entered", stop_flag, 1);
    chk("R2 forced div", div_sel, 3);
    chk("R7 xout high", xout_hi, 1);
    idle(3);
    irq_lvl[2*3 +: 3] = 3'd0; irq_req[2] = 1; gie = 1; idle(3);
    chk("R3 level zero no wake", stop_flag, 1);
    irq_req[2] = 0; irq_lvl[2*3 +: 3] = 3'd5; gie = 0; irq_req[2] = 1; idle(3);
    chk("R3 gie off no wake", stop_flag, 1);
    irq_req[2] = 0;
    wr(0, 2'b00, 0, 0, 0, 2'b00);
    chk("R10 write ignored", div_sel, 3);
    gie = 1; irq_req[2] = 1; idle(1); irq_req[2] = 0;
    chk("R3 woke", osc_en, 1);
    chk("R4 cpu held", cpu_clk_en, 0);
    idle(SETTLE - 1);
    chk("R4 settle end minus one", cpu_clk_en, 0);
    idle(1);
    chk("R4 cpu resumed", cpu_clk_en, 1);
    chk("R4 ack", wake_ack, 1);
    chk("R5 div kept", div_sel, 3);
    chk("R5 src kept", clk_src, 1);
    idle(2);

    wr(1, 2'b10, 0, 0, 0, 2'b00);
    chk("R7 input mode", xout_oe, 0);
    idle(4);
    rst_n = 0; #1;
    chk("R6 reset in stop", stop_flag, 0);
    chk("R6 reset clk", cpu_clk_en, 1);
    idle(2); rst_n = 1; idle(2);

    irq_lvl[5*3 +: 3] = 3'd1; irq_req[5] = 1; gie = 1;
    wr(1, 2'b00, 0, 1, 0, 2'b00);
    irq_req[5] = 0;
    chk("R9 no stop", stop_flag, 0);
    chk("R9 settling", cpu_clk_en, 0);
    chk("R9 forced div", div_sel, 3);
    idle(SETTLE + 3);
    chk("R9 back in run", cpu_clk_en, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule